// File: doc/BRIEF.md
# Immediate-Count Shift Unit

This block carries out one shift instruction per strobe: a 32-bit operand is shifted left, shifted right with zero fill, or shifted right with sign fill. The amount is an 8-bit immediate. The direction comes from the three-bit selector field inside the instruction's operand-description byte. The register-or-memory addressing part of that byte is not decoded here, because address generation happens elsewhere. The unit returns the shifted value, the four arithmetic flags (sign, zero, carry, overflow) and a write-enable for the destination. It raises an illegal-operation indication when the selector names a shift it does not implement.

The caller passes in the current flag state along with the operand. Several flag rules depend on the masked count. A count of zero leaves both value and flags alone. The overflow flag is only recomputed for single-bit shifts. For longer shifts the caller's overflow bit passes through. Results are registered: a one-cycle input strobe produces a one-cycle output strobe on the next clock.

Top module: `imm_shift_unit`

## Requirements
- R1: The selector is bits [5:3] of `in_modrm`. Value 4 selects left shift, 5 selects right shift with zero fill, and 7 selects right shift with sign fill. The other bits of `in_modrm` have no effect. Any other selector value gives `out_illegal`=1 and `out_wr_en`=0, with `out_result` equal to the operand and `out_flags` equal to `in_flags`.
- R2: The shift amount is `in_imm[4:0]` (0 to 31). Bits [7:5] of the immediate are ignored.
- R3: A left shift fills vacated low bits with zeros. For example, 0x0000000D shifted by 1 gives 0x0000001A.
- R4: The zero-fill right shift fills vacated high bits with zeros. For example, 0xFFFFFFFD by 1 gives 0x7FFFFFFE, and both 26 and 27 by 1 give 13.
- R5: The sign-fill right shift replicates operand bit 31. For example, 0xFFFFFFFD by 1 gives 0xFFFFFFFE.
- R6: The flag layout, for both `in_flags` and `out_flags`, is bit 3 = sign, bit 2 = zero, bit 1 = carry, bit 0 = overflow. With a nonzero count, the zero flag is set exactly when the result is zero. The sign flag is result bit 31 for the left and sign-fill shifts, and is always 0 for the zero-fill shift.
- R7: With a nonzero count, the carry flag is the last bit shifted out. For a left shift by n this is operand bit 32-n. For either right shift by n it is operand bit n-1.
- R8: With a count of exactly 1, the overflow flag is set as follows: left gives operand bit 31 XOR bit 30, zero-fill right gives operand bit 31, and sign-fill right gives 0. With a count of 2 or more, the overflow flag equals the incoming overflow bit.
- R9: For a legal selector with a masked count of 0, `out_result` equals the operand, `out_flags` equals `in_flags`, `out_wr_en` is 0 and `out_illegal` is 0.
- R10: `out_valid` rises on the clock after `in_valid` and lasts one cycle per strobe. `out_wr_en` and `out_illegal` are 0 whenever `out_valid` is 0. Reset clears `out_valid`, `out_wr_en` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_modrm | input | 8 | Operand-description byte; bits [5:3] select the shift |
| in_operand | input | 32 | Value to shift |
| in_imm | input | 8 | Immediate shift count; low 5 bits used |
| in_flags | input | 4 | Current flags {sign, zero, carry, overflow} |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Shifted value |
| out_flags | output | 4 | Updated flags {sign, zero, carry, overflow} |
| out_wr_en | output | 1 | Destination write-enable |
| out_illegal | output | 1 | Unimplemented selector |

## Verification
The bench targets the bit positions where shift logic tends to slip. It checks the carry at counts 1 and 31, where an off-by-one tap returns a neighbouring operand bit. It checks the sign bit of the two right shifts, which come out swapped if the fill source is crossed. It checks overflow at count 1 against counts above 1, where a design that always recomputes overflow clobbers the caller's bit. It also checks immediates with high bits set, which an unmasked count would turn into a shift of 32 or more and so zero the result. Finally, it checks count-zero and illegal-selector operations: a design that writes back or recomputes flags there would assert the write-enable or change the flags.

// File: rtl/shu_pkg.sv
package shu_pkg;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RZERO = 2'd1,
      SK_RSIGN = 2'd2,
      SK_NONE  = 2'd3
   } shift_kind_e;

   typedef struct packed {
      logic sf;
      logic zf;
      logic cf;
      logic of;
   } arith_flags_t;

   localparam int FLAGS_W = 4;

endpackage

// File: rtl/shu_decode.sv
module shu_decode
   import shu_pkg::*;
#(
   parameter int SEL_LSB    = 3,
   parameter int SEL_W      = 3,
   parameter int SEL_LEFT   = 4,
   parameter int SEL_RZERO  = 5,
   parameter int SEL_RSIGN  = 7
) (
   input  logic [7:0]  modrm,
   output shift_kind_e kind,
   output logic        illegal
);
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   generate
      if (SEL_MSB > 7) begin : g_bad_field
         $error("selector field exceeds the byte");
      end
   endgenerate

   logic [SEL_W-1:0] sel;
   assign sel = modrm[SEL_MSB:SEL_LSB];

   always_comb begin
      kind    = SK_NONE;
      illegal = 1'b0;
      if (sel == SEL_W'(SEL_LEFT))       kind = SK_LEFT;
      else if (sel == SEL_W'(SEL_RZERO)) kind = SK_RZERO;
      else if (sel == SEL_W'(SEL_RSIGN)) kind = SK_RSIGN;
      else                               illegal = 1'b1;
   end
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
   import shu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = $clog2(DATA_W),
   parameter int STYLE  = 0
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [CNT_W-1:0]  cnt,
   input  shift_kind_e       kind,
   output logic [DATA_W-1:0] result,
   output logic              carry
);
   localparam int EXT_W = DATA_W + 1;

   logic             is_left;
   logic             fill;
   logic [EXT_W-1:0] ext_in;
   logic [EXT_W-1:0] ext_out;

   assign is_left = (kind == SK_LEFT);
   assign fill    = (kind == SK_RSIGN) ? operand[DATA_W-1] : 1'b0;
   assign ext_in  = is_left ? {1'b0, operand} : {operand, 1'b0};

   generate
      if (STYLE == 0) begin : g_staged
         logic [EXT_W-1:0] stg [CNT_W+1];
         assign stg[0] = ext_in;
         for (genvar gi = 0; gi < CNT_W; gi++) begin : g_stage
            localparam int AMT = 1 << gi;
            logic [EXT_W-1:0] mask;
            logic [EXT_W-1:0] moved;
            assign mask  = fill ? ~({EXT_W{1'b1}} >> AMT) : '0;
            assign moved = is_left ? (stg[gi] << AMT)
                                   : ((stg[gi] >> AMT) | mask);
            assign stg[gi+1] = cnt[gi] ? moved : stg[gi];
         end
         assign ext_out = stg[CNT_W];
      end else begin : g_operator
         logic [EXT_W-1:0] mask;
         assign mask    = fill ? ~({EXT_W{1'b1}} >> cnt) : '0;
         assign ext_out = is_left ? (ext_in << cnt) : ((ext_in >> cnt) | mask);
      end
   endgenerate

   assign result = is_left ? ext_out[DATA_W-1:0] : ext_out[EXT_W-1:1];
   assign carry  = is_left ? ext_out[EXT_W-1]    : ext_out[0];
endmodule

// File: rtl/shu_flags.sv
module shu_flags
   import shu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = $clog2(DATA_W)
) (
   input  shift_kind_e       kind,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] result,
   input  logic              carry,
   input  arith_flags_t      flags_in,
   output arith_flags_t      flags_out
);
   logic single;
   assign single = (cnt == CNT_W'(1));

   always_comb begin
      flags_out.zf = (result == '0);
      flags_out.cf = carry;
      flags_out.sf = (kind == SK_RZERO) ? 1'b0 : result[DATA_W-1];
      flags_out.of = flags_in.of;
      if (single) begin
         unique case (kind)
            SK_LEFT:  flags_out.of = operand[DATA_W-1] ^ operand[DATA_W-2];
            SK_RZERO: flags_out.of = operand[DATA_W-1];
            SK_RSIGN: flags_out.of = 1'b0;
            default:  flags_out.of = flags_in.of;
         endcase
      end
   end
endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
   import shu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_modrm,
   input  logic [DATA_W-1:0] in_operand,
   input  logic [7:0]        in_imm,
   input  logic [3:0]        in_flags,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic [3:0]        out_flags,
   output logic              out_wr_en,
   output logic              out_illegal
);
   localparam int CNT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 2 || (1 << CNT_W) != DATA_W || CNT_W > 8) begin : g_bad_width
         $error("DATA_W must be a power of two between 2 and 256");
      end
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("STYLE must be 0 or 1");
      end
   endgenerate

   shift_kind_e       kind;
   logic              illegal;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shifted;
   logic              carry;
   arith_flags_t      flags_cur;
   arith_flags_t      flags_new;
   logic              hold;

   assign cnt       = in_imm[CNT_W-1:0];
   assign flags_cur = arith_flags_t'(in_flags);
   assign hold      = illegal || (cnt == '0);

   shu_decode i_decode (
      .modrm   (in_modrm),
      .kind    (kind),
      .illegal (illegal)
   );

   shu_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STYLE(STYLE)) i_shifter (
      .operand (in_operand),
      .cnt     (cnt),
      .kind    (kind),
      .result  (shifted),
      .carry   (carry)
   );

   shu_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_flags (
      .kind      (kind),
      .cnt       (cnt),
      .operand   (in_operand),
      .result    (shifted),
      .carry     (carry),
      .flags_in  (flags_cur),
      .flags_out (flags_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_wr_en   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
         out_flags   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= hold ? in_operand : shifted;
            out_flags   <= hold ? in_flags : 4'(flags_new);
            out_wr_en   <= !hold;
            out_illegal <= illegal;
         end else begin
            out_wr_en   <= 1'b0;
            out_illegal <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        in_modrm,
   input logic [DATA_W-1:0] in_operand,
   input logic [7:0]        in_imm,
   input logic [3:0]        in_flags,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_result,
   input logic [3:0]        out_flags,
   input logic              out_wr_en,
   input logic              out_illegal
);
   logic [2:0] sel;
   logic [4:0] c;
   logic       legal;
   assign sel   = in_modrm[5:3];
   assign c     = in_imm[4:0];
   assign legal = (sel == 3'd4) || (sel == 3'd5) || (sel == 3'd7);

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_wr_en && !out_illegal));
   assert_illegal_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> !out_wr_en);
   assert_illegal_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal) |=> (out_illegal && out_result == $past(in_operand)));
   assert_zero_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal && c == 5'd0) |=>
         (out_result == $past(in_operand) && out_flags == $past(in_flags) && !out_wr_en));
   assert_zero_fill_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 3'd5 && c != 5'd0) |=> !out_flags[3]);
   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal && c != 5'd0) |=> (out_flags[2] == (out_result == '0)));
   assert_sign_fill_of_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 3'd7 && c == 5'd1) |=> !out_flags[0]);
   assert_of_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal && c > 5'd1) |=> (out_flags[0] == $past(in_flags[0])));
   assert_sign_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 3'd7) |=> (out_result[DATA_W-1] == $past(in_operand[DATA_W-1])));
endmodule

bind imm_shift_unit shu_checker #(.DATA_W(DATA_W)) i_shu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_modrm   (in_modrm),
   .in_operand (in_operand),
   .in_imm     (in_imm),
   .in_flags   (in_flags),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_flags  (out_flags),
   .out_wr_en  (out_wr_en),
   .out_illegal(out_illegal)
);

// File: tb/test_imm_shift_unit.sv
module test_imm_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_modrm = '0;
   logic [31:0] in_operand = '0;
   logic [7:0]  in_imm = '0;
   logic [3:0]  in_flags = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [3:0]  out_flags;
   logic        out_wr_en;
   logic        out_illegal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   imm_shift_unit i_imm_shift_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_modrm(in_modrm),
      .in_operand(in_operand), .in_imm(in_imm), .in_flags(in_flags),
      .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags),
      .out_wr_en(out_wr_en), .out_illegal(out_illegal)
   );

   // {tag, modrm, operand, imm, flags_in, exp_result, exp_flags, exp_we, exp_ill}
   localparam int NV = 25;
   localparam logic [113:0] VEC [NV] = '{
      {"R3 ", 8'hE3, 32'h0000000D, 8'h01, 4'h0, 32'h0000001A, 4'h0, 1'b1, 1'b0},
      {"R4 ", 8'hEB, 32'h0000001A, 8'h01, 4'h0, 32'h0000000D, 4'h0, 1'b1, 1'b0},
      {"R4 ", 8'hEB, 32'h0000001B, 8'h01, 4'h0, 32'h0000000D, 4'h2, 1'b1, 1'b0},
      {"R5 ", 8'hFB, 32'h0000001A, 8'h01, 4'h0, 32'h0000000D, 4'h0, 1'b1, 1'b0},
      {"R5 ", 8'hFB, 32'hFFFFFFFD, 8'h01, 4'h0, 32'hFFFFFFFE, 4'hA, 1'b1, 1'b0},
      {"R4 ", 8'hEB, 32'hFFFFFFFD, 8'h01, 4'h0, 32'h7FFFFFFE, 4'h3, 1'b1, 1'b0},
      {"R8 ", 8'hE3, 32'h40000000, 8'h01, 4'h0, 32'h80000000, 4'h9, 1'b1, 1'b0},
      {"R8 ", 8'hE3, 32'h80000001, 8'h01, 4'h0, 32'h00000002, 4'h3, 1'b1, 1'b0},
      {"R6 ", 8'hE3, 32'h80000000, 8'h01, 4'h0, 32'h00000000, 4'h7, 1'b1, 1'b0},
      {"R8 ", 8'hE3, 32'h0000000F, 8'h04, 4'h1, 32'h000000F0, 4'h1, 1'b1, 1'b0},
      {"R8 ", 8'hE3, 32'h0000000F, 8'h04, 4'h0, 32'h000000F0, 4'h0, 1'b1, 1'b0},
      {"R2 ", 8'hE3, 32'h00000001, 8'h21, 4'h0, 32'h00000002, 4'h0, 1'b1, 1'b0},
      {"R2 ", 8'hEB, 32'h000000F0, 8'hE4, 4'h0, 32'h0000000F, 4'h0, 1'b1, 1'b0},
      {"R9 ", 8'hFB, 32'h12345678, 8'h20, 4'hF, 32'h12345678, 4'hF, 1'b0, 1'b0},
      {"R9 ", 8'hE3, 32'h12345678, 8'h00, 4'h5, 32'h12345678, 4'h5, 1'b0, 1'b0},
      {"R7 ", 8'hFB, 32'h80000000, 8'h1F, 4'h0, 32'hFFFFFFFF, 4'h8, 1'b1, 1'b0},
      {"R7 ", 8'hEB, 32'h80000000, 8'h1F, 4'h0, 32'h00000001, 4'h0, 1'b1, 1'b0},
      {"R7 ", 8'hE3, 32'h00000001, 8'h1F, 4'h0, 32'h80000000, 4'h8, 1'b1, 1'b0},
      {"R7 ", 8'hE3, 32'h00000003, 8'h1F, 4'h0, 32'h80000000, 4'hA, 1'b1, 1'b0},
      {"R6 ", 8'hEB, 32'h00000001, 8'h01, 4'h0, 32'h00000000, 4'h6, 1'b1, 1'b0},
      {"R1 ", 8'hC3, 32'hDEADBEEF, 8'h01, 4'h6, 32'hDEADBEEF, 4'h6, 1'b0, 1'b1},
      {"R1 ", 8'hF3, 32'hDEADBEEF, 8'h01, 4'h9, 32'hDEADBEEF, 4'h9, 1'b0, 1'b1},
      {"R8 ", 8'hFB, 32'h00000004, 8'h01, 4'h1, 32'h00000002, 4'h0, 1'b1, 1'b0},
      {"R1 ", 8'h25, 32'h00000005, 8'h02, 4'h0, 32'h00000014, 4'h0, 1'b1, 1'b0},
      {"R1 ", 8'hD3, 32'h00000005, 8'h00, 4'h0, 32'h00000005, 4'h0, 1'b0, 1'b1}
   };

   task automatic check(input logic [23:0] tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10", "reset out_valid", 32'(out_valid), 32'd0);
      check("R10", "reset out_wr_en", 32'(out_wr_en), 32'd0);
      check("R10", "reset out_illegal", 32'(out_illegal), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [113:0] v;
         v = VEC[i];
         in_modrm   = v[89:82];
         in_operand = v[81:50];
         in_imm     = v[49:42];
         in_flags   = v[41:38];
         in_valid   = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check("R10", $sformatf("vec %0d out_valid", i), 32'(out_valid), 32'd1);
         check(v[113:90], $sformatf("vec %0d result", i), out_result, v[37:6]);
         check(v[113:90], $sformatf("vec %0d flags", i), 32'(out_flags), 32'(v[5:2]));
         check(v[113:90], $sformatf("vec %0d wr_en", i), 32'(out_wr_en), 32'(v[1]));
         check(v[113:90], $sformatf("vec %0d illegal", i), 32'(out_illegal), 32'(v[0]));
      end

      // R10: single pulse; qualifiers drop, value held
      @(negedge clk);
      check("R10", "pulse ends", 32'(out_valid), 32'd0);
      check("R10", "wr_en quiet", 32'(out_wr_en), 32'd0);
      check("R10", "illegal quiet", 32'(out_illegal), 32'd0);
      check("R10", "result held", out_result, 32'h00000005);

      // R1: illegal op during idle input changes has no effect before the strobe
      in_modrm = 8'hC3; in_operand = 32'hFFFF0000; in_imm = 8'h01;
      @(negedge clk);
      check("R1", "no strobe no illegal", 32'(out_illegal), 32'd0);

      // R10: reset mid-stream clears the strobe
      in_modrm = 8'hE3; in_operand = 32'h1; in_imm = 8'h01; in_valid = 1'b1;
      @(posedge clk);
      #2 rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check("R10", "reset clears valid", 32'(out_valid), 32'd0);
      check("R10", "reset clears wr_en", 32'(out_wr_en), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R10 watchdog expired got hang exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule